// File: doc/BRIEF.md
# Glitch-Free Processor Clock Source Controller

This block picks the clock that feeds the processor core from three candidates: the external reference clock, the frequency synthesizer output divided by two, and a slow free-running ring-oscillator clock. It holds the synthesizer configuration: enable, use-synthesizer select, multiplier, divider and loop-filter trim. It drives those fields out to the analog loop and qualifies that loop's raw in-lock indication into a sticky lock flag.

Each source has its own enable handshake. An enable is taken away on that source's falling edge before the next source's enable is granted on its own falling edge, so the output never shows a shortened pulse. A power-mode input sits above the register selection. It can force the slow clock, or it can stop the output clock low. After a stop, the output resumes only through the same handshake.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the configuration reads zero, the lock flag is low, only the reference enable is active (src_en_o = 3'b001), and clk_o runs at the reference clock period.
- R2: A write stores wr_data_i. It reads back on cfg_o after the sampling edge and is decoded as bit 0 = synthesizer enable, bit 1 = use-synthesizer select, bits [6:2] = multiplier, bits [9:7] = divider, bits [13:10] = loop-filter trim.
- R3: Every write clears the lock flag at the same reference edge that stores the data.
- R4: Once the lock flag is set, it stays set whatever the raw in-lock input does, until the next write.
- R5: The lock flag sets only after the raw in-lock input has been high, with the synthesizer enabled, on 64 consecutive reference edges. It sets on the 64th such edge, and any low cycle restarts the count. With the enable bit clear it never sets.
- R6: With select set but lock not yet reached, clk_o stays on the reference clock.
- R7: With enable, select and lock all set, clk_o runs at half the synthesizer clock frequency (src_en_o = 3'b010).
- R8: Power mode 2'b01 forces the slow clock (src_en_o = 3'b100) even when the synthesizer is selected and locked.
- R9: Power mode 2'b10 or 2'b11 stops clk_o. It stays low with no enable active. Returning to mode 2'b00 brings back the register-selected source.
- R10: At most one source enable is active at any time, and no high or low pulse on clk_o is shorter than the shortest half period of the sources.
- R11: Clearing the enable bit while select is set returns clk_o to the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External reference clock; also clocks the register and the lock counter |
| vco_clk_i | input | 1 | Synthesizer output clock (before the divide by two) |
| slow_clk_i | input | 1 | Slow ring-oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 14 | Configuration write data |
| pwr_mode_i | input | 2 | 00 normal, 01 force slow, 1x stop clock |
| lock_raw_i | input | 1 | Raw in-lock indication from the loop |
| cfg_o | output | 14 | Configuration read-back |
| pll_en_o | output | 1 | Synthesizer enable to the loop |
| pll_mult_o | output | 5 | Multiplier setting |
| pll_div_o | output | 3 | Divider setting |
| pll_lf_o | output | 4 | Loop-filter trim |
| lock_o | output | 1 | Sticky qualified lock flag |
| src_en_o | output | 3 | Active source enables: bit 0 reference, bit 1 synthesizer, bit 2 slow |
| clk_o | output | 1 | Processor clock |

## Verification
The source selection is driven through every combination that matters: select without lock, select with lock, enable removed, forced slow over a locked synthesizer, and stop followed by resume. The reference, synthesizer and slow clocks have periods of 5 ns, 6 ns after division, and 40 ns. Each measured clk_o period therefore identifies one source without ambiguity. The lock qualifier is tried with a run one cycle short of the threshold, an exact run after a drop, a drop after lock, and a run with the enable bit clear. These separate an off-by-one count, a missing restart, a non-sticky flag and a missing enable gate. A pulse-width monitor across all switches catches a handshake that lets a shortened pulse through.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_VCO  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_SLOW = 2'b01,
    PWR_STOP = 2'b10,
    PWR_HALT = 2'b11
  } pwr_e;
endpackage

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg #(
  parameter int unsigned MUL_W = 5,
  parameter int unsigned DIV_W = 3,
  parameter int unsigned LF_W  = 4,
  localparam int unsigned CFG_W = MUL_W + DIV_W + LF_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             en_o,
  output logic             sel_o,
  output logic [MUL_W-1:0] mult_o,
  output logic [DIV_W-1:0] div_o,
  output logic [LF_W-1:0]  lf_o
);
  localparam int unsigned MUL_LSB = 2;
  localparam int unsigned DIV_LSB = MUL_LSB + MUL_W;
  localparam int unsigned LF_LSB  = DIV_LSB + DIV_W;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_data_i;
  end

  assign cfg_o  = cfg_q;
  assign en_o   = cfg_q[0];
  assign sel_o  = cfg_q[1];
  assign mult_o = cfg_q[MUL_LSB +: MUL_W];
  assign div_o  = cfg_q[DIV_LSB +: DIV_W];
  assign lf_o   = cfg_q[LF_LSB +: LF_W];

  a_r2_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cfg_o == $past(wr_data_i));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/lock_qual.sv
module lock_qual #(
  parameter int unsigned LOCK_CYCLES = 64,
  localparam int unsigned CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic raw_i,
  output logic lock_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      // detection freezes once locked
      if (en_i && raw_i) begin
        if (cnt_q == CNT_LAST) lock_q <= 1'b1;
        else                   cnt_q  <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign lock_o = lock_q;

  a_r3_write_clears_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lock_o);
  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !clr_i) |=> lock_o);
  a_r5_lock_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(raw_i && en_i));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter bit RST_ON = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic busy_o,
  output logic clk_o
);
  logic s1_q, s2_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_ON;
      s2_q <= RST_ON;
    end else begin
      s1_q <= req_i;
      s2_q <= s1_q;
    end
  end

  // enable moves only while this clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_ON;
    else         en_q <= s2_q;
  end

  assign en_o   = en_q;
  assign busy_o = s1_q | s2_q | en_q;
  assign clk_o  = clk_i & en_q;
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned MUL_W       = 5,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned LF_W        = 4,
  parameter int unsigned LOCK_CYCLES = 64,
  localparam int unsigned CFG_W = MUL_W + DIV_W + LF_W + 2
) (
  input  logic               clk_i,
  input  logic               vco_clk_i,
  input  logic               slow_clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  input  logic [1:0]         pwr_mode_i,
  input  logic               lock_raw_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               pll_en_o,
  output logic [MUL_W-1:0]   pll_mult_o,
  output logic [DIV_W-1:0]   pll_div_o,
  output logic [LF_W-1:0]    pll_lf_o,
  output logic               lock_o,
  output logic [NUM_SRC-1:0] src_en_o,
  output logic               clk_o
);
  logic pll_sel, pll_en, lock;
  logic vco_half_q;
  src_e target;
  logic [NUM_SRC-1:0] src_clk, req, en, busy, gated;

  pll_ctrl_reg #(.MUL_W(MUL_W), .DIV_W(DIV_W), .LF_W(LF_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg_o),
    .en_o      (pll_en),
    .sel_o     (pll_sel),
    .mult_o    (pll_mult_o),
    .div_o     (pll_div_o),
    .lf_o      (pll_lf_o)
  );

  lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_en_i),
    .en_i   (pll_en),
    .raw_i  (lock_raw_i),
    .lock_o (lock)
  );

  always_ff @(posedge vco_clk_i or negedge rst_ni) begin
    if (!rst_ni) vco_half_q <= 1'b0;
    else         vco_half_q <= ~vco_half_q;
  end

  always_comb begin
    if (pwr_mode_i[1])                   target = SRC_NONE;
    else if (pwr_mode_i == PWR_SLOW)     target = SRC_SLOW;
    else if (pll_en && pll_sel && lock)  target = SRC_VCO;
    else                                 target = SRC_REF;
  end

  assign src_clk = {slow_clk_i, vco_half_q, clk_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [NUM_SRC-1:0] others;
    assign others = busy & ~(NUM_SRC'(1) << g);
    // break before make: no grant while any other path is still live
    assign req[g] = (target == src_e'(g)) && (others == '0);

    clk_gate_cell #(.RST_ON(g == 0)) u_cell (
      .clk_i  (src_clk[g]),
      .rst_ni (rst_ni),
      .req_i  (req[g]),
      .en_o   (en[g]),
      .busy_o (busy[g]),
      .clk_o  (gated[g])
    );
  end

  assign clk_o    = |gated;
  assign src_en_o = en;
  assign lock_o   = lock;
  assign pll_en_o = pll_en;

  a_r10_single_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_en_o));
  a_r9_stop_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_i[1] |-> req == '0);
  a_r8_slow_only_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i == 2'b01) |-> !req[0] && !req[1]);
endmodule

// File: tb/clk_src_ctrl_tb.sv
`timescale 1ns/1ps
module clk_src_ctrl_tb;
  localparam int CFG_W = 14;

  logic clk = 1'b0, vco = 1'b0, slow = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [1:0] pwr = 2'b00;
  logic raw = 1'b0;
  logic [CFG_W-1:0] cfg;
  logic pll_en, lock, clk_out;
  logic [4:0] mult;
  logic [2:0] divv;
  logic [3:0] lf;
  logic [2:0] src_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  realtime last_edge = 0.0, min_pulse = 1.0e9;

  always #2.5 clk  = ~clk;
  always #1.5 vco  = ~vco;
  always #20  slow = ~slow;

  clk_src_ctrl u_dut (
    .clk_i(clk), .vco_clk_i(vco), .slow_clk_i(slow), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .pwr_mode_i(pwr), .lock_raw_i(raw),
    .cfg_o(cfg), .pll_en_o(pll_en), .pll_mult_o(mult), .pll_div_o(divv),
    .pll_lf_o(lf), .lock_o(lock), .src_en_o(src_en), .clk_o(clk_out)
  );

  always @(clk_out) begin
    if (mon_on) begin
      if (last_edge > 0.0 && ($realtime - last_edge) < min_pulse)
        min_pulse = $realtime - last_edge;
      last_edge = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic period_ps(output longint p);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = longint'(($realtime - t0) * 1000.0);
  endtask

  function automatic logic [CFG_W-1:0] pack(input bit en, input bit sel,
      input int m, input int d, input int l);
    return {4'(l), 3'(d), 5'(m), sel, en};
  endfunction

  task automatic check_src(input string req, input longint exp_ps,
                           input logic [2:0] exp_en);
    longint p;
    #1000;
    @(negedge clk);
    chk(src_en == exp_en, req, "source enables", src_en, exp_en);
    period_ps(p);
    chk(p == exp_ps, req, "clk_o period ps", p, exp_ps);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] d;
    bit stuck_low;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(cfg == '0, "R1", "cfg after reset", cfg, 0);
    chk(lock == 1'b0, "R1", "lock after reset", lock, 0);
    check_src("R1", 5000, 3'b001);

    // R2 field sweep, enable kept 0 so no lock
    for (int i = 0; i < 8; i++) begin
      int m = (i * 7 + 3) % 32;
      int dv = (i * 3 + 1) % 8;
      int l = (15 - i * 2) & 15;
      d = pack(1'b0, i[0], m, dv, l);
      write_cfg(d);
      chk(cfg == d, "R2", "readback", cfg, d);
      chk(mult == 5'(m) && divv == 3'(dv) && lf == 4'(l) && pll_en == 1'b0,
          "R2", "field decode", {lf, divv, mult}, {4'(l), 3'(dv), 5'(m)});
    end

    // R5 enable clear blocks lock (select set, enable off)
    write_cfg(pack(1'b0, 1'b1, 10, 2, 5));
    raw = 1'b1;
    repeat (100) @(negedge clk);
    chk(lock == 1'b0, "R5", "lock with enable clear", lock, 0);
    raw = 1'b0;

    // R6 select without lock stays on reference
    write_cfg(pack(1'b1, 1'b1, 10, 2, 5));
    check_src("R6", 5000, 3'b001);

    // R5 count 63 short, drop, then exact 64
    write_cfg(pack(1'b1, 1'b1, 10, 2, 5));
    raw = 1'b1;
    repeat (63) @(negedge clk);
    chk(lock == 1'b0, "R5", "lock after 63", lock, 0);
    raw = 1'b0;
    @(negedge clk);
    raw = 1'b1;
    repeat (63) @(negedge clk);
    chk(lock == 1'b0, "R5", "lock after restart 63", lock, 0);
    @(negedge clk);
    chk(lock == 1'b1, "R5", "lock on 64th", lock, 1);

    // R4 sticky through raw drop
    raw = 1'b0;
    repeat (20) @(negedge clk);
    chk(lock == 1'b1, "R4", "lock after raw drop", lock, 1);

    // R7 synthesizer half rate
    check_src("R7", 6000, 3'b010);

    // R8 force slow over locked synthesizer
    pwr = 2'b01;
    check_src("R8", 40000, 3'b100);

    // R9 stop, held low
    pwr = 2'b10;
    #1000;
    @(negedge clk);
    chk(src_en == 3'b000, "R9", "enables while stopped", src_en, 0);
    stuck_low = 1'b1;
    for (int k = 0; k < 300; k++) begin
      #1;
      if (clk_out !== 1'b0) stuck_low = 1'b0;
    end
    chk(stuck_low, "R9", "clk_o held low", stuck_low, 1);
    pwr = 2'b11;
    #200;
    chk(clk_out == 1'b0 && src_en == 3'b000, "R9", "mode 11 stopped", src_en, 0);
    pwr = 2'b00;
    check_src("R9", 6000, 3'b010);

    // R3 write clears lock, falls back to reference
    write_cfg(pack(1'b1, 1'b1, 10, 2, 5));
    chk(lock == 1'b0, "R3", "lock after write", lock, 0);
    check_src("R3", 5000, 3'b001);

    // relock, then R11 clear enable
    raw = 1'b1;
    repeat (64) @(negedge clk);
    chk(lock == 1'b1, "R5", "relock", lock, 1);
    raw = 1'b0;
    check_src("R7", 6000, 3'b010);
    write_cfg(pack(1'b0, 1'b1, 10, 2, 5));
    check_src("R11", 5000, 3'b001);

    // R10 no short pulses anywhere
    chk(longint'(min_pulse * 1000.0) >= 2500, "R10", "min pulse ps",
        longint'(min_pulse * 1000.0), 2500);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule